// File: doc/BRIEF.md
# Four-Mode Control Register

A register of configurable width. On each rising clock edge, a two-bit mode input selects one of four operations. The register can keep its value, take a word from a parallel bus, clear itself to zero, or move down by one place. In the shift-down mode, a serial input bit fills the top position and the bottom bit is lost. An active-low asynchronous reset forces the contents to zero at any time, whatever the mode.

The block suits control and staging registers that need explicit clear and serial-in paths next to a normal load. Rotation, upward shifting and sign-preserving shifts are not provided.

Top module: `mode_shift_reg`

## Requirements
- R1: While rst_ni is low, q_o is all zeros, and it goes to zero without waiting for a clock edge.
- R2: With mode_i = 2'b00 at a rising edge, q_o keeps its previous value.
- R3: With mode_i = 2'b01 at a rising edge, q_o takes the value of par_i.
- R4: With mode_i = 2'b10 at a rising edge, q_o becomes all zeros.
- R5: With mode_i = 2'b11 at a rising edge, bit i of q_o takes the old bit i+1, bit WIDTH-1 takes ser_i, and the old bit 0 is discarded.
- R6: ser_i has no effect on q_o in modes 2'b00, 2'b01 and 2'b10.
- R7: par_i has no effect on q_o in modes 2'b00, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operation select: 00 hold, 01 load, 10 clear, 11 shift down |
| par_i | input | WIDTH | Parallel load data |
| ser_i | input | 1 | Serial bit that enters the top position during a shift |
| q_o | output | WIDTH | Register contents |

## Verification
The properties assume that mode_i, par_i and ser_i are stable around each rising edge. They also assume that rst_ni is released away from an edge, so the value sampled at the edge is the value the register used. The bench changes every data and mode input only on the falling clock edge. It asserts and releases reset between edges as well, and it covers all four modes with random data and serial bits, including inputs that the selected mode should ignore.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_SHDN  = 2'b11
  } mode_e;

  typedef struct packed {
    logic load;
    logic clr;
    logic shd;
  } sel_t;
endpackage

// File: rtl/msr_decode.sv
module msr_decode
  import msr_pkg::*;
(
  input  logic [1:0] mode_i,
  output sel_t       sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (mode_e'(mode_i))
      MODE_LOAD:  sel_o.load = 1'b1;
      MODE_CLEAR: sel_o.clr  = 1'b1;
      MODE_SHDN:  sel_o.shd  = 1'b1;
      default:    sel_o      = '0;
    endcase
  end
endmodule

// File: rtl/msr_slice.sv
module msr_slice
  import msr_pkg::*;
(
  input  sel_t sel_i,
  input  logic cur_i,
  input  logic par_i,
  input  logic upper_i,
  output logic nxt_o
);
  always_comb begin
    if (sel_i.clr)       nxt_o = 1'b0;
    else if (sel_i.load) nxt_o = par_i;
    else if (sel_i.shd)  nxt_o = upper_i;
    else                 nxt_o = cur_i;
  end
endmodule

// File: rtl/msr_state.sv
module msr_state #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mode_shift_reg.sv
module mode_shift_reg
  import msr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  sel_t             sel;
  logic [WIDTH-1:0] q_cur;
  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] upper;

  msr_decode u_dec (
    .mode_i (mode_i),
    .sel_o  (sel)
  );

  // shift source: each bit sees its upper neighbour, top bit sees ser_i
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == WIDTH - 1) begin : g_top
        assign upper[i] = ser_i;
      end else begin : g_mid
        assign upper[i] = q_cur[i+1];
      end
      msr_slice u_slice (
        .sel_i   (sel),
        .cur_i   (q_cur[i]),
        .par_i   (par_i[i]),
        .upper_i (upper[i]),
        .nxt_o   (q_nxt[i])
      );
    end
  endgenerate

  msr_state #(.WIDTH(WIDTH)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (q_nxt),
    .q_o    (q_cur)
  );

  assign q_o = q_cur;
endmodule

// File: rtl/mode_shift_reg_chk.sv
module mode_shift_reg_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] par_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] q_o
);
  logic             armed;
  logic [WIDTH-1:0] shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // expected shift result built from the sampled inputs of the previous edge
  always_ff @(posedge clk_i) shifted <= {ser_i, q_o} >> 1;

  AST_RESET_ZERO: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0); // R1
  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(mode_i) == 2'b00 |-> q_o == $past(q_o)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(mode_i) == 2'b01 |-> q_o == $past(par_i)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(mode_i) == 2'b10 |-> q_o == '0); // R4
  AST_SHIFT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(mode_i) == 2'b11 |-> q_o == shifted); // R5
endmodule

bind mode_shift_reg mode_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .par_i  (par_i),
  .ser_i  (ser_i),
  .q_o    (q_o)
);

// File: tb/mode_shift_reg_test.sv
`timescale 1ns/1ps
module mode_shift_reg_test;
  localparam int unsigned W = 4;

  typedef struct {
    string          tag;
    logic [W-1:0]   val;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [1:0]   mode_i = 2'b00;
  logic [W-1:0] par_i = '0;
  logic         ser_i = 1'b0;
  logic [W-1:0] q_o;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;
  exp_t exp_q[$];

  mode_shift_reg #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .par_i(par_i), .ser_i(ser_i), .q_o(q_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q_o=%b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply inputs at falling edge, predict next value, push it
  task automatic drive(logic [1:0] m, logic [W-1:0] p, logic s, string tag);
    exp_t e;
    @(negedge clk_i);
    mode_i = m; par_i = p; ser_i = s;
    case (m)
      2'b00: model = model;
      2'b01: model = p;
      2'b10: model = '0;
      default: model = {s, model[W-1:1]};
    endcase
    e.tag = tag;
    e.val = model;
    exp_q.push_back(e);
  endtask

  // monitor: just after each rising edge, compare against the oldest prediction
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.tag, q_o, e.val);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    #10;
    check("R1 reset", q_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    model = '0;

    drive(2'b01, 4'b1011, 1'b0, "R3 load");
    drive(2'b00, 4'b0101, 1'b1, "R2 hold, R6 R7 ignored");
    drive(2'b11, 4'b1111, 1'b0, "R5 shift ser0, R7");
    drive(2'b11, 4'b0000, 1'b1, "R5 shift ser1, R7");
    drive(2'b11, 4'b1010, 1'b1, "R5 shift ser1");
    drive(2'b01, 4'b0110, 1'b1, "R3 load, R6 ser ignored");
    drive(2'b10, 4'b1111, 1'b1, "R4 clear, R6 R7 ignored");
    drive(2'b00, 4'b1001, 1'b0, "R2 hold zero");
    drive(2'b01, 4'b1111, 1'b0, "R3 load all ones");
    for (int k = 0; k < W; k++) drive(2'b11, 4'b1111, 1'b0, "R5 shift out");
    drain();

    // asynchronous reset between edges
    drive(2'b01, 4'b1110, 1'b0, "R3 load before reset");
    drain();
    #0.5 rst_ni = 1'b0;
    #0.5 check("R1 async reset", q_o, '0);
    mode_i = 2'b01; par_i = 4'b1111;
    @(posedge clk_i); #1 check("R1 held during reset", q_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    mode_i = 2'b00;
    model = '0;

    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      drive(m, W'($urandom), 1'($urandom),
            m == 2'b00 ? "R2 random hold" :
            m == 2'b01 ? "R3 random load" :
            m == 2'b10 ? "R4 random clear" : "R5 random shift");
    end
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule